// File: doc/BRIEF.md
# Exception and Interrupt Event Arbiter

This block sits beside a processor pipeline and decides, every clock, which single event the core services next. Three request groups arrive together: reset sources, general exceptions raised by the instruction stream or the memory system, and one pending interrupt that an external interrupt controller has already prioritised. The block ranks the groups as reset first, general exceptions second and interrupts last. It breaks ties inside each group with a fixed order. It then presents the winner's event code, its vector offset, an action class and what the current instruction must do.

A block-bit input marks the core as unable to take a nested exception. While it is set, most general exceptions are turned into a reset. Breakpoint-type events are dropped. A DMA address error is parked inside the block and offered again once the block bit clears, and an interrupt is reported as waiting. Two event registers record what was taken. The exception-event register captures the code of an accepted reset or general exception. The interrupt-event register captures the source code of an accepted interrupt. Every decision is registered, so outputs follow the inputs by one clock.

Top module: `exc_event_arbiter`

## Requirements
- R1: Reset requests use `rst_req` bit 0 = power-on (code 0xA00), bit 1 = manual (0x020), bit 2 = debug-interface (0x000), with the lower bit winning. A reset presents action 0 (reset), vector offset 0x000 and disposition 0 (abort).
- R2: Any reset request wins over all general exception and interrupt requests in the same cycle.
- R3: `gen_req` bits are ranked with the lowest bit winning. The bits and codes are: 0 = break before execution (0x1E0), 1 = instruction-fetch address error (0x0E0), 2 = illegal general instruction (0x180), 3 = illegal slot instruction (0x1A0), 4 = data address error, 5 = unconditional trap (0x160), 6 = break after execution (0x1E0), 7 = DMA address error (0x5C0). With the block bit clear, the winner is presented with action 1 (handle) and vector 0x100.
- R4: A data address error reports code 0x0E0 when `dae_write` is 0 and 0x100 when it is 1.
- R5: Disposition is 1 (re-execute) for `gen_req` bits 0 to 4. It is 2 (complete) for bits 5 to 7, for interrupts and for ignored or held events.
- R6: An interrupt is chosen only when no reset and no general request is active. It presents `irq_code` with vector 0x600. When accepted while handled, it loads `intevt` and leaves `expevt` unchanged.
- R7: With `bl`=1, a winning general request other than bits 0, 6 and 7 gets action 0 (reset), vector 0x000 and disposition abort. Bits 0 and 6 get action 2 (ignore).
- R8: With `bl`=1, a DMA address error or an interrupt gets action 3 (hold). A held DMA request stays internally pending after its input drops. It is handled on the first cycle after `bl` returns to 0 and stays pending until that handle is accepted.
- R9: `expevt` loads the presented code only when `accept` is high while a valid reset-action or handle-action non-interrupt event is presented, including a reset caused by `bl`. Ignored and held events load neither register.
- R10: With no active request, `ev_valid`=0, `idle`=1, code and vector read 0, disposition reads 3 (none), and neither event register changes even if `accept` is high.
- R11: All outputs change one clock after the inputs that cause them. A synchronous `rst` clears both event registers and any held request, and shows the idle outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req | input | 3 | Reset source requests |
| gen_req | input | 8 | General exception requests, bit 0 highest |
| dae_write | input | 1 | Data address error came from a write |
| bl | input | 1 | Block bit: nested exceptions blocked |
| irq_pend | input | 1 | Interrupt pending from the interrupt controller |
| irq_code | input | 12 | Source code of the pending interrupt |
| accept | input | 1 | Core accepts the presented event |
| ev_valid | output | 1 | An event is presented |
| idle | output | 1 | No event is presented |
| ev_code | output | 12 | Code of the presented event |
| ev_vec | output | 12 | Vector offset of the presented event |
| ev_action | output | 2 | 0 reset, 1 handle, 2 ignore, 3 hold |
| ev_disp | output | 2 | 0 abort, 1 re-execute, 2 complete, 3 none |
| expevt | output | 12 | Exception-event register |
| intevt | output | 12 | Interrupt-event register |

## Verification
The bench goes after collisions across levels and within a level. Examples are a trap together with a post-execution break, and an interrupt alongside a trap. A design with the wrong tie order or a leaky interrupt gate would present the wrong code or let an interrupt overtake an exception. It sweeps the block bit over each class of general exception: a design with the wrong split would escalate a breakpoint to reset, or hand the core an exception it cannot take. It drops a DMA request while it is parked and then clears the block bit. A design without the internal hold would lose the event, and one that never clears the hold would repeat it after acceptance. It also accepts interrupts, ignored events and idle cycles and watches the event registers: a design that routes an interrupt into `expevt` or loads on an ignore would corrupt the recorded cause.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

  localparam int CODE_W  = 12;
  localparam int VEC_W   = 12;
  localparam int NUM_RST = 3;
  localparam int NUM_GEN = 8;
  localparam int RST_IW  = $clog2(NUM_RST);
  localparam int GEN_IW  = $clog2(NUM_GEN);

  // general request bit positions (lower index wins)
  localparam int GI_BRK_PRE  = 0;
  localparam int GI_IFETCH   = 1;
  localparam int GI_ILL_GEN  = 2;
  localparam int GI_ILL_SLOT = 3;
  localparam int GI_DATA_ERR = 4;
  localparam int GI_TRAP     = 5;
  localparam int GI_BRK_POST = 6;
  localparam int GI_DMA_ERR  = 7;

  localparam logic [VEC_W-1:0] VEC_RESET = VEC_W'(12'h000);
  localparam logic [VEC_W-1:0] VEC_GEN   = VEC_W'(12'h100);
  localparam logic [VEC_W-1:0] VEC_IRQ   = VEC_W'(12'h600);

  typedef enum logic [1:0] {
    ACT_RESET  = 2'd0,
    ACT_HANDLE = 2'd1,
    ACT_IGNORE = 2'd2,
    ACT_HOLD   = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    DISP_ABORT    = 2'd0,
    DISP_REEXEC   = 2'd1,
    DISP_COMPLETE = 2'd2,
    DISP_NONE     = 2'd3
  } disp_e;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] code;
    logic [VEC_W-1:0]  vec;
    act_e              act;
    disp_e             disp;
    logic              is_irq;
    logic              is_dma;
  } sel_t;

  function automatic logic [CODE_W-1:0] rst_code(input logic [RST_IW-1:0] idx);
    case (idx)
      RST_IW'(0): rst_code = CODE_W'(12'hA00);
      RST_IW'(1): rst_code = CODE_W'(12'h020);
      default:    rst_code = CODE_W'(12'h000);
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] gen_code(input logic [GEN_IW-1:0] idx,
                                                  input logic wr);
    case (int'(idx))
      GI_BRK_PRE:  gen_code = CODE_W'(12'h1E0);
      GI_IFETCH:   gen_code = CODE_W'(12'h0E0);
      GI_ILL_GEN:  gen_code = CODE_W'(12'h180);
      GI_ILL_SLOT: gen_code = CODE_W'(12'h1A0);
      GI_DATA_ERR: gen_code = wr ? CODE_W'(12'h100) : CODE_W'(12'h0E0);
      GI_TRAP:     gen_code = CODE_W'(12'h160);
      GI_BRK_POST: gen_code = CODE_W'(12'h1E0);
      default:     gen_code = CODE_W'(12'h5C0);
    endcase
  endfunction

  // events raised before or during execution repeat the instruction
  function automatic logic gen_reexec(input logic [GEN_IW-1:0] idx);
    gen_reexec = (int'(idx) <= GI_DATA_ERR);
  endfunction

  // breakpoint-type events are dropped while blocked
  function automatic logic gen_dropped(input logic [GEN_IW-1:0] idx);
    gen_dropped = (int'(idx) == GI_BRK_PRE) || (int'(idx) == GI_BRK_POST);
  endfunction

endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N:0]    seen;
  logic [IW-1:0] idx_ch [0:N];

  assign seen[0]   = 1'b0;
  assign idx_ch[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign seen[g+1]   = seen[g] | req[g];
    assign idx_ch[g+1] = (req[g] && !seen[g]) ? IW'(g) : idx_ch[g];
  end

  assign any = seen[N];
  assign idx = idx_ch[N];
endmodule

// File: rtl/exc_policy.sv
module exc_policy
  import exc_arb_pkg::*;
(
  input  logic              rst_any,
  input  logic [RST_IW-1:0] rst_idx,
  input  logic              gen_any,
  input  logic [GEN_IW-1:0] gen_idx,
  input  logic              dae_write,
  input  logic              bl,
  input  logic              irq_pend,
  input  logic [CODE_W-1:0] irq_code,
  output sel_t              nxt
);
  always_comb begin
    nxt      = '0;
    nxt.act  = ACT_RESET;
    nxt.disp = DISP_NONE;
    if (rst_any) begin
      nxt.valid = 1'b1;
      nxt.code  = rst_code(rst_idx);
      nxt.vec   = VEC_RESET;
      nxt.act   = ACT_RESET;
      nxt.disp  = DISP_ABORT;
    end else if (gen_any) begin
      nxt.valid  = 1'b1;
      nxt.code   = gen_code(gen_idx, dae_write);
      nxt.is_dma = (int'(gen_idx) == GI_DMA_ERR);
      if (!bl) begin
        nxt.act  = ACT_HANDLE;
        nxt.vec  = VEC_GEN;
        nxt.disp = gen_reexec(gen_idx) ? DISP_REEXEC : DISP_COMPLETE;
      end else if (gen_dropped(gen_idx)) begin
        nxt.act  = ACT_IGNORE;
        nxt.vec  = VEC_GEN;
        nxt.disp = DISP_COMPLETE;
      end else if (int'(gen_idx) == GI_DMA_ERR) begin
        nxt.act  = ACT_HOLD;
        nxt.vec  = VEC_GEN;
        nxt.disp = DISP_COMPLETE;
      end else begin
        nxt.act  = ACT_RESET;
        nxt.vec  = VEC_RESET;
        nxt.disp = DISP_ABORT;
      end
    end else if (irq_pend) begin
      nxt.valid  = 1'b1;
      nxt.code   = irq_code;
      nxt.vec    = VEC_IRQ;
      nxt.is_irq = 1'b1;
      nxt.act    = bl ? ACT_HOLD : ACT_HANDLE;
      nxt.disp   = DISP_COMPLETE;
    end
  end
endmodule

// File: rtl/exc_event_regs.sv
module exc_event_regs
  import exc_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  sel_t              nxt,
  input  logic              accept,
  output sel_t              cur,
  output logic              dma_hold,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt
);
  logic take;
  logic load_exp;
  logic load_int;
  logic hold_set;
  logic hold_clr;

  assign take     = accept && cur.valid;
  assign load_exp = take && !cur.is_irq &&
                    ((cur.act == ACT_RESET) || (cur.act == ACT_HANDLE));
  assign load_int = take && cur.is_irq && (cur.act == ACT_HANDLE);
  assign hold_set = nxt.valid && nxt.is_dma && (nxt.act == ACT_HOLD);
  assign hold_clr = take && cur.is_dma && (cur.act == ACT_HANDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= '0;
      cur.disp <= DISP_NONE;
      dma_hold <= 1'b0;
      expevt   <= '0;
      intevt   <= '0;
    end else begin
      cur <= nxt;
      if (hold_set)      dma_hold <= 1'b1;
      else if (hold_clr) dma_hold <= 1'b0;
      if (load_exp) expevt <= cur.code;
      if (load_int) intevt <= cur.code;
    end
  end
endmodule

// File: rtl/exc_event_arbiter.sv
module exc_event_arbiter
  import exc_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_RST-1:0] rst_req,
  input  logic [NUM_GEN-1:0] gen_req,
  input  logic               dae_write,
  input  logic               bl,
  input  logic               irq_pend,
  input  logic [CODE_W-1:0]  irq_code,
  input  logic               accept,
  output logic               ev_valid,
  output logic               idle,
  output logic [CODE_W-1:0]  ev_code,
  output logic [VEC_W-1:0]   ev_vec,
  output logic [1:0]         ev_action,
  output logic [1:0]         ev_disp,
  output logic [CODE_W-1:0]  expevt,
  output logic [CODE_W-1:0]  intevt
);
  logic               dma_hold;
  logic [NUM_GEN-1:0] gen_eff;
  logic               rst_any;
  logic [RST_IW-1:0]  rst_idx;
  logic               gen_any;
  logic [GEN_IW-1:0]  gen_idx;
  sel_t               nxt;
  sel_t               cur;

  // a parked DMA error keeps competing in the general level
  always_comb begin
    gen_eff             = gen_req;
    gen_eff[GI_DMA_ERR] = gen_req[GI_DMA_ERR] | dma_hold;
  end

  exc_prio_pick #(.N(NUM_RST), .IW(RST_IW)) u_rst_pick (
    .req (rst_req),
    .any (rst_any),
    .idx (rst_idx)
  );

  exc_prio_pick #(.N(NUM_GEN), .IW(GEN_IW)) u_gen_pick (
    .req (gen_eff),
    .any (gen_any),
    .idx (gen_idx)
  );

  exc_policy u_policy (
    .rst_any   (rst_any),
    .rst_idx   (rst_idx),
    .gen_any   (gen_any),
    .gen_idx   (gen_idx),
    .dae_write (dae_write),
    .bl        (bl),
    .irq_pend  (irq_pend),
    .irq_code  (irq_code),
    .nxt       (nxt)
  );

  exc_event_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .nxt      (nxt),
    .accept   (accept),
    .cur      (cur),
    .dma_hold (dma_hold),
    .expevt   (expevt),
    .intevt   (intevt)
  );

  assign ev_valid  = cur.valid;
  assign idle      = !cur.valid;
  assign ev_code   = cur.code;
  assign ev_vec    = cur.vec;
  assign ev_action = cur.act;
  assign ev_disp   = cur.disp;
endmodule

// File: rtl/exc_event_arbiter_chk.sv
module exc_event_arbiter_chk
  import exc_arb_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [NUM_GEN-1:0] gen_req,
  input logic               bl,
  input logic               accept,
  input logic               ev_valid,
  input logic [CODE_W-1:0]  ev_code,
  input logic [VEC_W-1:0]   ev_vec,
  input logic [1:0]         ev_action,
  input logic [1:0]         ev_disp,
  input logic [CODE_W-1:0]  expevt,
  input logic [CODE_W-1:0]  intevt
);
  // R1: a reset action always aborts the instruction
  a_r1_reset_aborts: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_action == 2'd0) |-> (ev_disp == 2'd0));

  // R6: an interrupt is handled only after a cycle with no general request
  a_r6_irq_alone: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_vec == VEC_IRQ && ev_action == 2'd1) |-> ($past(gen_req) == '0));

  // R6: accepting an interrupt leaves the exception-event register alone
  a_r6_irq_keeps_expevt: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && accept && ev_vec == VEC_IRQ) |=> $stable(expevt));

  // R7: while blocked, nothing is handled
  a_r7_bl_no_handle: assert property (@(posedge clk) disable iff (rst)
    ($past(bl) && ev_valid) |-> (ev_action != 2'd1));

  // R9: an accepted reset action records its code
  a_r9_expevt_load: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && accept && ev_action == 2'd0) |=> (expevt == $past(ev_code)));

  // R10: an idle cycle changes neither event register
  a_r10_idle_regs_hold: assert property (@(posedge clk) disable iff (rst)
    (!ev_valid) |=> ($stable(expevt) && $stable(intevt)));

  // R10: idle shows no disposition
  a_r10_idle_disp: assert property (@(posedge clk) disable iff (rst)
    (!ev_valid) |-> (ev_disp == 2'd3));
endmodule

bind exc_event_arbiter exc_event_arbiter_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .gen_req   (gen_req),
  .bl        (bl),
  .accept    (accept),
  .ev_valid  (ev_valid),
  .ev_code   (ev_code),
  .ev_vec    (ev_vec),
  .ev_action (ev_action),
  .ev_disp   (ev_disp),
  .expevt    (expevt),
  .intevt    (intevt)
);

// File: tb/exc_event_arbiter_tb.sv
module exc_event_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  rst_req;
  logic [7:0]  gen_req;
  logic        dae_write, bl, irq_pend, accept;
  logic [11:0] irq_code;
  logic        ev_valid, idle;
  logic [11:0] ev_code, ev_vec, expevt, intevt;
  logic [1:0]  ev_action, ev_disp;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  exc_event_arbiter u_dut (
    .clk(clk), .rst(rst), .rst_req(rst_req), .gen_req(gen_req),
    .dae_write(dae_write), .bl(bl), .irq_pend(irq_pend), .irq_code(irq_code),
    .accept(accept), .ev_valid(ev_valid), .idle(idle), .ev_code(ev_code),
    .ev_vec(ev_vec), .ev_action(ev_action), .ev_disp(ev_disp),
    .expevt(expevt), .intevt(intevt)
  );

  // {rst3, gen8, wr, bl, irq, valid, code12, vec12, act2, disp2}
  localparam int NV = 23;
  localparam logic [42:0] TBL [0:NV-1] = '{
    {3'b001, 8'h00, 3'b000, 1'b1, 12'hA00, 12'h000, 2'd0, 2'd0}, // R1
    {3'b110, 8'h00, 3'b000, 1'b1, 12'h020, 12'h000, 2'd0, 2'd0}, // R1
    {3'b100, 8'h00, 3'b000, 1'b1, 12'h000, 12'h000, 2'd0, 2'd0}, // R1
    {3'b001, 8'hFF, 3'b001, 1'b1, 12'hA00, 12'h000, 2'd0, 2'd0}, // R2
    {3'b000, 8'h01, 3'b000, 1'b1, 12'h1E0, 12'h100, 2'd1, 2'd1}, // R3
    {3'b000, 8'h02, 3'b000, 1'b1, 12'h0E0, 12'h100, 2'd1, 2'd1}, // R3
    {3'b000, 8'h0C, 3'b000, 1'b1, 12'h180, 12'h100, 2'd1, 2'd1}, // R3
    {3'b000, 8'h08, 3'b000, 1'b1, 12'h1A0, 12'h100, 2'd1, 2'd1}, // R3
    {3'b000, 8'h10, 3'b000, 1'b1, 12'h0E0, 12'h100, 2'd1, 2'd1}, // R4
    {3'b000, 8'h10, 3'b100, 1'b1, 12'h100, 12'h100, 2'd1, 2'd1}, // R4
    {3'b000, 8'h20, 3'b000, 1'b1, 12'h160, 12'h100, 2'd1, 2'd2}, // R5
    {3'b000, 8'h40, 3'b000, 1'b1, 12'h1E0, 12'h100, 2'd1, 2'd2}, // R5
    {3'b000, 8'h60, 3'b000, 1'b1, 12'h160, 12'h100, 2'd1, 2'd2}, // R3
    {3'b000, 8'h80, 3'b000, 1'b1, 12'h5C0, 12'h100, 2'd1, 2'd2}, // R5
    {3'b000, 8'hA0, 3'b000, 1'b1, 12'h160, 12'h100, 2'd1, 2'd2}, // R3
    {3'b000, 8'h00, 3'b001, 1'b1, 12'h3A0, 12'h600, 2'd1, 2'd2}, // R6
    {3'b000, 8'h20, 3'b001, 1'b1, 12'h160, 12'h100, 2'd1, 2'd2}, // R6
    {3'b000, 8'h02, 3'b010, 1'b1, 12'h0E0, 12'h000, 2'd0, 2'd0}, // R7
    {3'b000, 8'h01, 3'b010, 1'b1, 12'h1E0, 12'h100, 2'd2, 2'd2}, // R7
    {3'b000, 8'h40, 3'b010, 1'b1, 12'h1E0, 12'h100, 2'd2, 2'd2}, // R7
    {3'b000, 8'h00, 3'b011, 1'b1, 12'h3A0, 12'h600, 2'd3, 2'd2}, // R8
    {3'b010, 8'h00, 3'b010, 1'b1, 12'h020, 12'h000, 2'd0, 2'd0}, // R2
    {3'b000, 8'h00, 3'b000, 1'b0, 12'h000, 12'h000, 2'd0, 2'd3}  // R10
  };

  function automatic string tag_of(input int i);
    if (i < 3)       tag_of = "R1";
    else if (i == 3) tag_of = "R2";
    else if (i < 8)  tag_of = "R3";
    else if (i < 10) tag_of = "R4";
    else if (i < 15) tag_of = "R5";
    else if (i < 17) tag_of = "R6";
    else if (i < 20) tag_of = "R7";
    else if (i < 21) tag_of = "R8";
    else if (i < 22) tag_of = "R2";
    else             tag_of = "R10";
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] obs();
    obs = {3'b000, ev_valid, ev_code, ev_vec, ev_action, ev_disp};
  endfunction

  task automatic drive(input logic [2:0] r, input logic [7:0] g, input logic wr,
                       input logic b, input logic irq, input logic [11:0] ic,
                       input logic acc);
    rst_req = r; gen_req = g; dae_write = wr; bl = b;
    irq_pend = irq; irq_code = ic; accept = acc;
  endtask

  task automatic quiet();
    drive(3'b0, 8'h0, 1'b0, 1'b0, 1'b0, 12'h0, 1'b0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    drive(3'b0, 8'h0, 1'b0, 1'b0, 1'b0, 12'h0, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk("R11", "reset outputs", obs(), {3'b000, 1'b0, 12'h000, 12'h000, 2'd0, 2'd3});
    chk("R11", "reset idle", {31'd0, idle}, 32'd1);
    chk("R11", "reset regs", {8'd0, expevt, intevt}, 32'd0);

    // table walk: drive at a falling edge, sample one clock later
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i][42:40], TBL[i][39:32], TBL[i][31], TBL[i][30], TBL[i][29],
            12'h3A0, 1'b0);
      @(negedge clk);
      chk(tag_of(i), $sformatf("vector %0d", i), obs(), {3'b000, TBL[i][28:0]});
    end
    chk("R9", "no accept no load", {20'd0, expevt}, 32'd0);
    quiet();

    // R9 general exception accepted
    drive(3'b0, 8'h04, 1'b0, 1'b0, 1'b0, 12'h0, 1'b1);
    @(negedge clk); @(negedge clk);
    chk("R9", "expevt after accept", {20'd0, expevt}, 32'h180);
    chk("R9", "intevt untouched", {20'd0, intevt}, 32'h000);
    quiet();

    // R6 interrupt accepted
    drive(3'b0, 8'h00, 1'b0, 1'b0, 1'b1, 12'h3A0, 1'b1);
    @(negedge clk); @(negedge clk);
    chk("R6", "intevt after accept", {20'd0, intevt}, 32'h3A0);
    chk("R6", "expevt kept", {20'd0, expevt}, 32'h180);
    quiet();

    // R9 escalated reset under block bit loads expevt
    drive(3'b0, 8'h08, 1'b0, 1'b1, 1'b0, 12'h0, 1'b1);
    @(negedge clk);
    chk("R7", "escalated action", {30'd0, ev_action}, 32'd0);
    @(negedge clk);
    chk("R9", "expevt on bl reset", {20'd0, expevt}, 32'h1A0);
    quiet();

    // R9 ignored break with accept does not load
    drive(3'b0, 8'h01, 1'b0, 1'b1, 1'b0, 12'h0, 1'b1);
    @(negedge clk); @(negedge clk);
    chk("R9", "ignore keeps expevt", {20'd0, expevt}, 32'h1A0);
    quiet();

    // R8 held interrupt with accept does not load
    drive(3'b0, 8'h00, 1'b0, 1'b1, 1'b1, 12'h555, 1'b1);
    @(negedge clk); @(negedge clk);
    chk("R8", "held irq keeps intevt", {20'd0, intevt}, 32'h3A0);
    quiet();

    // R10 accept while idle changes nothing
    drive(3'b0, 8'h00, 1'b0, 1'b0, 1'b0, 12'h0, 1'b1);
    @(negedge clk); @(negedge clk);
    chk("R10", "idle accept regs", {8'd0, expevt, intevt}, {8'd0, 12'h1A0, 12'h3A0});
    chk("R10", "idle flag", {31'd0, idle}, 32'd1);
    quiet();

    // R8 DMA error parked while blocked, then released
    drive(3'b0, 8'h80, 1'b0, 1'b1, 1'b0, 12'h0, 1'b0);
    @(negedge clk);
    chk("R8", "dma held", obs(), {3'b000, 1'b1, 12'h5C0, 12'h100, 2'd3, 2'd2});
    gen_req = 8'h00;
    @(negedge clk);
    chk("R8", "dma retained", obs(), {3'b000, 1'b1, 12'h5C0, 12'h100, 2'd3, 2'd2});
    bl = 1'b0;
    @(negedge clk);
    chk("R8", "dma released", obs(), {3'b000, 1'b1, 12'h5C0, 12'h100, 2'd1, 2'd2});
    accept = 1'b1;
    @(negedge clk);
    chk("R9", "dma accepted expevt", {20'd0, expevt}, 32'h5C0);
    accept = 1'b0;
    @(negedge clk);
    chk("R8", "dma hold cleared", {31'd0, ev_valid}, 32'd0);

    // R11 synchronous reset clears registers
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11", "regs after reset", {8'd0, expevt, intevt}, 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule